// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

This block turns a stream of bytes, one per clock on an 8-bit bus, into register writes. Each command is six consecutive bytes. The first two bytes hold a 16-bit address, low byte first. The next four hold a 32-bit data word, least significant byte first. A strobe input marks the first byte of each command.

The received address is checked against a base value under a mask, with defaults of 0x0780 and 0x07E0. The mask leaves five address bits free, which gives 32 local registers. On a match the block issues a one-cycle write enable together with the 5-bit local register index. That pulse comes a fixed number of cycles (three by default) before the assembled data word appears. Downstream decode logic can therefore select its target register ahead of time and latch the data in a later pipeline stage.

Commands may follow each other with no gap. A strobe that arrives in the middle of a command drops the partial command and starts a new one at that byte.

Top module: `cmd_byte_deser`

## Requirements
- R1: The bytes of a command are taken in the order address low, address high, data byte 0, data byte 1, data byte 2, data byte 3. The data output is {byte3, byte2, byte1, byte0}, so byte 0 lands in bits 7:0.
- R2: Bytes presented while no command is in progress and `cmdStb` is low are ignored. They cause no write pulse and no change of `wrData`.
- R3: A command is accepted only when (address & 0x07E0) == (0x0780 & 0x07E0). Address bits outside the mask, including bits 15:11, have no effect. A command that does not match gives no pulse and leaves `wrData` unchanged.
- R4: When `wrEn` is high, `localAddr` equals bits 4:0 of the received address.
- R5: For an accepted command whose strobe is in cycle t, `wrEn` is high in cycle t+3 only, so it is a single-cycle pulse.
- R6: `wrData` changes only in cycle t+6 of an accepted and completed command, where it shows that command's data word. Otherwise it holds its value.
- R7: A new strobe in the cycle right after the last data byte of the previous command starts a new command, and both commands are processed.
- R8: A strobe before the sixth byte drops the partial command and starts a new one at that byte. The dropped command never updates `wrData`. Its `wrEn` pulse appears only if it reached cycle t+3 before the new strobe arrived.
- R9: `rst` is synchronous. While it is high, the block returns to idle and drops any partial command. One cycle after it is sampled high, `wrEn` is 0, `localAddr` is 0 and `wrData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdByte | input | 8 | Serial command byte |
| cmdStb | input | 1 | High with the first byte of a command |
| wrEn | output | 1 | One-cycle write enable for an accepted command |
| localAddr | output | 5 | Local register index, valid with `wrEn` |
| wrData | output | 32 | Assembled data word, held until the next accepted command completes |

## Verification
Two events can fall in the same cycle. First, the byte position at which the write pulse is decided can coincide with a restarting strobe. The bench provokes this by sending a strobe as the third byte of a command, and it expects no pulse from the abandoned command and normal handling of the new one. Second, one command's data word can appear while the next command's address byte arrives. The bench sends commands back to back with no gap. On every clock it compares pulse timing, the local index and the data word against a behavioural model that tracks byte positions on its own.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;
  localparam int IDX_W = 4;  // byte position field, up to 16 bytes per command

  typedef struct packed {
    logic             take;    // a byte of a live command is on the bus
    logic [IDX_W-1:0] idx;     // its position within the command
    logic             fire;    // decide the write pulse at this byte
    logic             commit;  // last byte: complete the data word
  } deserCtl_t;
endpackage

// File: rtl/cmd_deser_ctrl.sv
module cmd_deser_ctrl
  import cmd_deser_pkg::*;
#(
  parameter int SEQ_LEN  = 6,
  parameter int FIRE_IDX = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdStb,
  output deserCtl_t ctl
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SEQ_LEN - 1);
  localparam logic [IDX_W-1:0] FIRE_POS = IDX_W'(FIRE_IDX);

  logic             busy;
  logic [IDX_W-1:0] nextPos;

  always_comb begin
    ctl.take   = cmdStb | busy;
    ctl.idx    = cmdStb ? '0 : nextPos;
    ctl.fire   = ctl.take && (ctl.idx == FIRE_POS);
    ctl.commit = ctl.take && (ctl.idx == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      nextPos <= '0;
    end else if (ctl.take) begin
      if (ctl.idx == LAST_POS) begin
        busy    <= 1'b0;
        nextPos <= '0;
      end else begin
        busy    <= 1'b1;
        nextPos <= ctl.idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_deser_dp.sv
module cmd_deser_dp
  import cmd_deser_pkg::*;
#(
  parameter int unsigned BASE_ADDR  = 'h0780,
  parameter int unsigned ADDR_MASK  = 'h07E0,
  parameter int          ADDR_BYTES = 2,
  parameter int          DATA_BYTES = 4,
  parameter int          LOCAL_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [7:0]                cmdByte,
  input  deserCtl_t                 ctl,
  output logic                      wrEn,
  output logic [LOCAL_W-1:0]        localAddr,
  output logic [DATA_BYTES*8-1:0]   wrData
);
  localparam int SEQ_LEN = ADDR_BYTES + DATA_BYTES;
  localparam int ADDR_W  = ADDR_BYTES * 8;
  localparam int DATA_W  = DATA_BYTES * 8;
  localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR) & MASK_V;

  logic [7:0]        held [SEQ_LEN-1];
  logic [ADDR_W-1:0] rxAddr;
  logic [DATA_W-1:0] dataNext;
  logic              addrHit;
  logic              matchHold;

  genvar g;
  generate
    for (g = 0; g < SEQ_LEN - 1; g++) begin : g_hold
      always_ff @(posedge clk) begin
        if (ctl.take && (ctl.idx == IDX_W'(g))) held[g] <= cmdByte;
      end
    end
    for (g = 0; g < ADDR_BYTES; g++) begin : g_addr
      assign rxAddr[8*g +: 8] = held[g];
    end
    for (g = 0; g < DATA_BYTES - 1; g++) begin : g_data
      assign dataNext[8*g +: 8] = held[ADDR_BYTES + g];
    end
  endgenerate

  assign dataNext[DATA_W-1 -: 8] = cmdByte;
  assign addrHit = (rxAddr & MASK_V) == BASE_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn      <= 1'b0;
      localAddr <= '0;
      matchHold <= 1'b0;
      wrData    <= '0;
    end else begin
      wrEn <= ctl.fire && addrHit;
      if (ctl.fire) begin
        matchHold <= addrHit;
        if (addrHit) localAddr <= rxAddr[LOCAL_W-1:0];
      end
      if (ctl.commit && matchHold) wrData <= dataNext;
    end
  end
endmodule

// File: rtl/cmd_byte_deser.sv
module cmd_byte_deser
  import cmd_deser_pkg::*;
#(
  parameter int unsigned BASE_ADDR  = 'h0780,
  parameter int unsigned ADDR_MASK  = 'h07E0,
  parameter int          ADDR_BYTES = 2,
  parameter int          DATA_BYTES = 4,
  parameter int          LOCAL_W    = 5,
  parameter int          EARLY      = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              cmdByte,
  input  logic                    cmdStb,
  output logic                    wrEn,
  output logic [LOCAL_W-1:0]      localAddr,
  output logic [DATA_BYTES*8-1:0] wrData
);
  localparam int SEQ_LEN = ADDR_BYTES + DATA_BYTES;
  // the pulse is registered one edge after the deciding byte;
  // this index must not be below ADDR_BYTES
  localparam int FIRE_IDX = SEQ_LEN - EARLY - 1;

  deserCtl_t ctl;

  cmd_deser_ctrl #(
    .SEQ_LEN  (SEQ_LEN),
    .FIRE_IDX (FIRE_IDX)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cmdStb (cmdStb),
    .ctl    (ctl)
  );

  cmd_deser_dp #(
    .BASE_ADDR  (BASE_ADDR),
    .ADDR_MASK  (ADDR_MASK),
    .ADDR_BYTES (ADDR_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .LOCAL_W    (LOCAL_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .cmdByte   (cmdByte),
    .ctl       (ctl),
    .wrEn      (wrEn),
    .localAddr (localAddr),
    .wrData    (wrData)
  );
endmodule

// File: rtl/cmd_byte_deser_chk.sv
module cmd_byte_deser_chk #(
  parameter int unsigned BASE_ADDR  = 'h0780,
  parameter int unsigned ADDR_MASK  = 'h07E0,
  parameter int          ADDR_BYTES = 2,
  parameter int          DATA_BYTES = 4,
  parameter int          LOCAL_W    = 5,
  parameter int          EARLY      = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [7:0]              cmdByte,
  input logic                    cmdStb,
  input logic                    wrEn,
  input logic [LOCAL_W-1:0]      localAddr,
  input logic [DATA_BYTES*8-1:0] wrData
);
  localparam int SEQ_LEN = ADDR_BYTES + DATA_BYTES;
  localparam logic [15:0] MASK_V = 16'(ADDR_MASK);
  localparam logic [15:0] BASE_V = 16'(BASE_ADDR) & MASK_V;

  logic [7:0] sinceStb;
  logic [7:0] capLo;
  logic [7:0] capHi;

  always_ff @(posedge clk) begin
    if (rst) sinceStb <= 8'hFF;
    else if (cmdStb) sinceStb <= 8'd1;
    else if (sinceStb != 8'hFF) sinceStb <= sinceStb + 8'd1;
    if (cmdStb) capLo <= cmdByte;
    else if (sinceStb == 8'd1) capHi <= cmdByte;
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !wrEn); // R5
  AST_WE_TIMING: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (sinceStb == 8'(SEQ_LEN - EARLY))); // R5
  AST_WE_MATCH: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (({capHi, capLo} & MASK_V) == BASE_V)); // R3
  AST_LOCAL_IDX: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (localAddr == capLo[LOCAL_W-1:0])); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(wrData) |-> (sinceStb == 8'(SEQ_LEN))); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!wrEn && (wrData == '0) && (localAddr == '0))); // R9
endmodule

bind cmd_byte_deser cmd_byte_deser_chk #(
  .BASE_ADDR  (BASE_ADDR),
  .ADDR_MASK  (ADDR_MASK),
  .ADDR_BYTES (ADDR_BYTES),
  .DATA_BYTES (DATA_BYTES),
  .LOCAL_W    (LOCAL_W),
  .EARLY      (EARLY)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdByte   (cmdByte),
  .cmdStb    (cmdStb),
  .wrEn      (wrEn),
  .localAddr (localAddr),
  .wrData    (wrData)
);

// File: tb/test_cmd_byte_deser.sv
`timescale 1ns/1ps
module test_cmd_byte_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmdByte = 8'h00;
  logic        cmdStb = 1'b0;
  logic        wrEn;
  logic [4:0]  localAddr;
  logic [31:0] wrData;

  always #2.5 clk = ~clk;

  cmd_byte_deser i_cmd_byte_deser (
    .clk (clk), .rst (rst), .cmdByte (cmdByte), .cmdStb (cmdStb),
    .wrEn (wrEn), .localAddr (localAddr), .wrData (wrData)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string phase = "R9 reset";

  // behavioural reference
  int          pos = -1;
  logic [7:0]  mb [6];
  bit          mMatch = 1'b0;
  bit          ready = 1'b0;
  bit          expWe = 1'b0;
  logic [4:0]  expLocal = '0;
  logic [31:0] expData = '0;

  always @(posedge clk) begin
    if (rst) begin
      pos = -1; mMatch = 1'b0; expWe = 1'b0; expLocal = '0; expData = '0;
      ready = 1'b1;
    end else begin
      expWe = 1'b0;
      if (cmdStb) pos = 0;
      else if (pos >= 0) pos++;
      if (pos > 5) pos = -1;
      if (pos >= 0) begin
        mb[pos] = cmdByte;
        if (pos == 2) begin
          mMatch = (({mb[1], mb[0]} & 16'h07E0) == 16'h0780);
          if (mMatch) begin
            expWe = 1'b1;
            expLocal = mb[0][4:0];
          end
        end
        if (pos == 5 && mMatch) expData = {mb[5], mb[4], mb[3], mb[2]};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ready && !done) begin
      chk("R5", {31'd0, wrEn}, {31'd0, expWe});
      if (expWe) chk("R4", {27'd0, localAddr}, {27'd0, expLocal});
      chk("R6", wrData, expData);
    end
  end

  task automatic putByte(input logic [7:0] b, input logic s);
    @(negedge clk);
    cmdByte = b;
    cmdStb = s;
  endtask

  task automatic sendCmd(input logic [15:0] a, input logic [31:0] d);
    putByte(a[7:0], 1'b1);
    putByte(a[15:8], 1'b0);
    for (int k = 0; k < 4; k++) putByte(d[8*k +: 8], 1'b0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) putByte(8'h5A, 1'b0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R9", {31'd0, wrEn}, 32'd0);
    chk("R9", wrData, 32'd0);
    chk("R9", {27'd0, localAddr}, 32'd0);
    rst = 1'b0;

    phase = "R1 R5 basic command";
    sendCmd(16'h0785, 32'hA1B2C3D4);
    idle(8);

    phase = "R3 non-matching addresses";
    sendCmd(16'h0800, 32'h0BADF00D);
    sendCmd(16'h07A0, 32'h0BADBEEF);
    idle(8);

    phase = "R3 upper bits outside mask";
    sendCmd(16'hF79F, 32'h11223344);
    idle(8);

    phase = "R2 stray bytes without strobe";
    for (int k = 0; k < 9; k++) putByte(8'h80 + 8'(k), 1'b0);
    idle(4);

    phase = "R7 back-to-back commands";
    sendCmd(16'h0781, 32'h01010101);
    sendCmd(16'h1234, 32'h02020202);
    sendCmd(16'h079E, 32'h03030303);
    sendCmd(16'h0790, 32'h04040404);
    idle(8);

    phase = "R8 restart on pulse byte";
    putByte(8'h82, 1'b1);
    putByte(8'h07, 1'b0);
    sendCmd(16'h0783, 32'hCAFE0001);
    idle(8);

    phase = "R8 restart after pulse";
    putByte(8'h84, 1'b1);
    putByte(8'h07, 1'b0);
    putByte(8'hEE, 1'b0);
    putByte(8'hEE, 1'b0);
    sendCmd(16'h0786, 32'hCAFE0002);
    idle(8);

    phase = "R6 hold while idle";
    idle(12);

    phase = "R9 reset mid-command";
    putByte(8'h88, 1'b1);
    putByte(8'h07, 1'b0);
    putByte(8'h99, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    cmdStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", wrData, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) putByte(8'h77, 1'b0);
    idle(6);

    phase = "R1 after reset";
    sendCmd(16'h078F, 32'h89ABCDEF);
    idle(8);

    done = 1'b1;
    finishRun();
  end
endmodule